// File: doc/BRIEF.md
# Physical Register Reclaim Tracker

This block keeps the life-cycle state of every physical register in a pool used by an out-of-order core. For each register it holds three flags (busy, mapped, in-window), a count of outstanding readers and a count of how many rename mappings point at it. Event ports, each a valid bit plus a register index, report reader arrivals and departures, map acquire and release, writeback completion, and the start of a write to a special register. An allocate request takes a register off the free list.

A normal register goes back to the free list only when every holder has let go. That means it has no mappings, it has left the window and it has no waiting readers. Freed registers are pushed at the head of a last-in first-out list, so the most recently freed register is handed out next. A small group of special registers, the low indices, is permanently mapped. Once such a register has no more readers and has left the window, it drops back to a mapped-idle state and is never put on the list.

Top module: `prt_reclaim_tracker`

## Requirements
- R1: After reset, registers 0 to NUM_SPECIAL-1 show mapped only, every other register shows no flag, the free head is NUM_SPECIAL and the free-available output is 1.
- R2: An allocate request while the list is non-empty pops the head. The edge that takes the request makes alloc_gnt_o 1 and alloc_idx_o the popped index, and sets busy and in-window for that register. The head then advances; with fresh registers only, it advances in ascending index order.
- R3: An allocate request while the list is empty and no register is being freed is ignored. alloc_err_o is 1 for one cycle, alloc_gnt_o stays 0 and the head stays at the all-ones value.
- R4: A map acquire on a normal register increments its map count and sets mapped. A map release decrements the count, and mapped clears only when the count reaches zero.
- R5: A writeback event clears the in-window flag of the register it names.
- R6: A reader-add event increments the reader count and a reader-done event decrements it. A reader-done at count zero leaves the count at zero and makes ref_err_o 1 for one cycle.
- R7: A normal register with busy set, mapped and in-window clear and zero readers is freed on the next edge, whatever order its holders were released in. Freeing clears all of its flags.
- R8: A freed register becomes the free head, and the list is last-in first-out: the next allocate returns the register freed most recently.
- R9: When a free and an allocate fall on the same edge, the free is applied first. The allocate receives the freed index, alloc_err_o stays 0, and the head does not change.
- R10: A write-start event on a special register sets busy and in-window. A special register that is busy and mapped, out of the window and has zero readers returns to mapped only on the next edge. A special register never appears as the free head, and map events on special registers have no effect.
- R11: At most one normal register is freed per edge. When several are eligible, the lowest index goes first and the others follow on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req_i | input | 1 | Request one register from the free list |
| alloc_gnt_o | output | 1 | Registered: the last request was served |
| alloc_idx_o | output | IDX_W | Registered: index handed out |
| alloc_err_o | output | 1 | Registered: the last request found the list empty |
| occupy_vld_i | input | 1 | A write to a special register starts |
| occupy_idx_i | input | IDX_W | Register index for occupy |
| wb_vld_i | input | 1 | Writeback complete |
| wb_idx_i | input | IDX_W | Register index for writeback |
| macq_vld_i | input | 1 | Map acquire |
| macq_idx_i | input | IDX_W | Register index for map acquire |
| mrel_vld_i | input | 1 | Map release |
| mrel_idx_i | input | IDX_W | Register index for map release |
| radd_vld_i | input | 1 | Reader added |
| radd_idx_i | input | IDX_W | Register index for reader added |
| rdone_vld_i | input | 1 | Reader finished |
| rdone_idx_i | input | IDX_W | Register index for reader finished |
| free_head_o | output | IDX_W | Current free head, all ones when empty |
| free_avail_o | output | 1 | Free list non-empty |
| busy_o | output | NUM_REGS | Busy flag per register |
| mapped_o | output | NUM_REGS | Mapped flag per register |
| inwin_o | output | NUM_REGS | In-window flag per register |
| ref_err_o | output | 1 | Registered: a reader-done hit a zero count |

## Verification
Freeing a register and allocating one can land on the same edge. This matters most when the list is empty, because the allocate can succeed only by taking the register that is being freed. The bench provokes this by releasing a register's last holder and raising the allocate request in the very next cycle. It does this once with the list empty and once with another register already on it. The bench expects the freed index to be granted with no error while the head stays where it was. A second overlap is provoked by making two normal registers eligible on the same edge through different event ports. The bench expects them to reach the head one edge apart, lowest index first.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef struct packed {
    logic busy;
    logic mapped;
    logic inwin;
  } reg_flags_t;
endpackage

// File: rtl/prt_reg_state.sv
module prt_reg_state
  import prt_pkg::*;
#(
  parameter bit IS_SPECIAL = 1'b0,
  parameter int REF_W      = 4,
  parameter int MAP_W      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       alloc_hit,
  input  logic       occupy_hit,
  input  logic       wb_hit,
  input  logic       macq_hit,
  input  logic       mrel_hit,
  input  logic       radd_hit,
  input  logic       rdone_hit,
  input  logic       free_hit,
  output reg_flags_t flags_o,
  output logic       reclaim_o,
  output logic       ref_err_o
);
  reg_flags_t flags_q, flags_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [MAP_W-1:0] map_q, map_d;
  logic err_d, idle;

  assign idle = !flags_q.inwin && (ref_q == '0);

  always_comb begin
    flags_d = flags_q;
    ref_d   = ref_q;
    map_d   = map_q;
    err_d   = 1'b0;
    if (wb_hit) flags_d.inwin = 1'b0;
    if (radd_hit && !rdone_hit) begin
      ref_d = ref_q + 1'b1;
    end else if (rdone_hit && !radd_hit) begin
      if (ref_q == '0) err_d = 1'b1;
      else             ref_d = ref_q - 1'b1;
    end
    if (IS_SPECIAL) begin
      if (occupy_hit) begin
        flags_d.busy  = 1'b1;
        flags_d.inwin = 1'b1;
      end else if (flags_q.busy && flags_q.mapped && idle) begin
        flags_d.busy = 1'b0;
      end
    end else begin
      if (macq_hit && !mrel_hit) begin
        map_d          = map_q + 1'b1;
        flags_d.mapped = 1'b1;
      end else if (mrel_hit && !macq_hit && map_q != '0) begin
        map_d = map_q - 1'b1;
        if (map_q == MAP_W'(1)) flags_d.mapped = 1'b0;
      end
      if (free_hit) begin
        flags_d = '0;
        ref_d   = '0;
        map_d   = '0;
      end
      if (alloc_hit) begin
        flags_d = '{busy: 1'b1, mapped: 1'b0, inwin: 1'b1};
        ref_d   = '0;
        map_d   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '{busy: 1'b0, mapped: IS_SPECIAL, inwin: 1'b0};
      ref_q     <= '0;
      map_q     <= MAP_W'(IS_SPECIAL);
      ref_err_o <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      ref_q     <= ref_d;
      map_q     <= map_d;
      ref_err_o <= err_d;
    end
  end

  assign flags_o   = flags_q;
  assign reclaim_o = !IS_SPECIAL && flags_q.busy && !flags_q.mapped && idle;

  // R6
  ref_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    ref_err_o |-> $past(rdone_hit));

  // R7
  free_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (free_hit && !alloc_hit) |=> (flags_q == '0));

  if (!IS_SPECIAL) begin : g_map_chk
    // R4
    map_flag_chk: assert property (@(posedge clk) disable iff (rst)
      flags_q.mapped == (map_q != '0));
  end
endmodule

// File: rtl/prt_pick.sv
module prt_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     sel_o,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    sel_o = '0;
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
        vld_o    = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prt_free_list.sv
module prt_free_list #(
  parameter int NUM_REGS    = 8,
  parameter int NUM_SPECIAL = 2,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic             pop_ok_o,
  output logic [IDX_W-1:0] pop_idx_o,
  output logic [IDX_W-1:0] head_o
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] NONE = '1;

  logic [IDX_W-1:0] next_q [NUM_REGS];
  logic [IDX_W-1:0] stk_q, stk_d, fill_q, fill_d;
  logic stk_empty, fresh_avail, wr_en;

  assign stk_empty   = (stk_q == NONE);
  assign fresh_avail = (fill_q < IDX_W'(NUM_REGS));
  assign head_o      = !stk_empty ? stk_q : (fresh_avail ? fill_q : NONE);

  always_comb begin
    stk_d     = stk_q;
    fill_d    = fill_q;
    pop_ok_o  = 1'b0;
    pop_idx_o = NONE;
    wr_en     = 1'b0;
    if (push_i && pop_i) begin
      pop_ok_o  = 1'b1;
      pop_idx_o = push_idx_i;
    end else if (push_i) begin
      wr_en = 1'b1;
      stk_d = push_idx_i;
    end else if (pop_i) begin
      if (!stk_empty) begin
        pop_ok_o  = 1'b1;
        pop_idx_o = stk_q;
        stk_d     = next_q[stk_q[PTR_W-1:0]];
      end else if (fresh_avail) begin
        pop_ok_o  = 1'b1;
        pop_idx_o = fill_q;
        fill_d    = fill_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) next_q[push_idx_i[PTR_W-1:0]] <= stk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_q  <= NONE;
      fill_q <= IDX_W'(NUM_SPECIAL);
    end else begin
      stk_q  <= stk_d;
      fill_q <= fill_d;
    end
  end

  // R8
  push_head_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> (head_o == $past(push_idx_i)));

  // R9
  same_edge_head_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> (head_o == $past(head_o)));
endmodule

// File: rtl/prt_reclaim_tracker.sv
module prt_reclaim_tracker
  import prt_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int NUM_SPECIAL = 2,
  parameter int REF_W       = 4,
  parameter int MAP_W       = 3,
  localparam int IDX_W      = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_req_i,
  output logic                alloc_gnt_o,
  output logic [IDX_W-1:0]    alloc_idx_o,
  output logic                alloc_err_o,
  input  logic                occupy_vld_i,
  input  logic [IDX_W-1:0]    occupy_idx_i,
  input  logic                wb_vld_i,
  input  logic [IDX_W-1:0]    wb_idx_i,
  input  logic                macq_vld_i,
  input  logic [IDX_W-1:0]    macq_idx_i,
  input  logic                mrel_vld_i,
  input  logic [IDX_W-1:0]    mrel_idx_i,
  input  logic                radd_vld_i,
  input  logic [IDX_W-1:0]    radd_idx_i,
  input  logic                rdone_vld_i,
  input  logic [IDX_W-1:0]    rdone_idx_i,
  output logic [IDX_W-1:0]    free_head_o,
  output logic                free_avail_o,
  output logic [NUM_REGS-1:0] busy_o,
  output logic [NUM_REGS-1:0] mapped_o,
  output logic [NUM_REGS-1:0] inwin_o,
  output logic                ref_err_o
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] NONE = '1;

  logic [NUM_REGS-1:0] reclaim_v, free_sel, err_v;
  logic [NUM_REGS-1:0] alloc_hit, occ_hit, wb_hit, macq_hit, mrel_hit, radd_hit, rdone_hit;
  logic                free_vld, pop_ok;
  logic [IDX_W-1:0]    free_idx, pop_idx;

  prt_pick #(.N(NUM_REGS), .IDX_W(IDX_W)) u_pick (
    .req_i (reclaim_v),
    .sel_o (free_sel),
    .vld_o (free_vld),
    .idx_o (free_idx)
  );

  prt_free_list #(.NUM_REGS(NUM_REGS), .NUM_SPECIAL(NUM_SPECIAL), .IDX_W(IDX_W)) u_list (
    .clk        (clk),
    .rst        (rst),
    .push_i     (free_vld),
    .push_idx_i (free_idx),
    .pop_i      (alloc_req_i),
    .pop_ok_o   (pop_ok),
    .pop_idx_o  (pop_idx),
    .head_o     (free_head_o)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [IDX_W-1:0] ME = IDX_W'(g);
    reg_flags_t fl;

    assign alloc_hit[g] = pop_ok && (pop_idx == ME);
    assign occ_hit[g]   = occupy_vld_i && (occupy_idx_i == ME);
    assign wb_hit[g]    = wb_vld_i && (wb_idx_i == ME);
    assign macq_hit[g]  = macq_vld_i && (macq_idx_i == ME);
    assign mrel_hit[g]  = mrel_vld_i && (mrel_idx_i == ME);
    assign radd_hit[g]  = radd_vld_i && (radd_idx_i == ME);
    assign rdone_hit[g] = rdone_vld_i && (rdone_idx_i == ME);

    prt_reg_state #(
      .IS_SPECIAL (g < NUM_SPECIAL),
      .REF_W      (REF_W),
      .MAP_W      (MAP_W)
    ) u_state (
      .clk        (clk),
      .rst        (rst),
      .alloc_hit  (alloc_hit[g]),
      .occupy_hit (occ_hit[g]),
      .wb_hit     (wb_hit[g]),
      .macq_hit   (macq_hit[g]),
      .mrel_hit   (mrel_hit[g]),
      .radd_hit   (radd_hit[g]),
      .rdone_hit  (rdone_hit[g]),
      .free_hit   (free_sel[g]),
      .flags_o    (fl),
      .reclaim_o  (reclaim_v[g]),
      .ref_err_o  (err_v[g])
    );

    assign busy_o[g]   = fl.busy;
    assign mapped_o[g] = fl.mapped;
    assign inwin_o[g]  = fl.inwin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_gnt_o <= 1'b0;
      alloc_idx_o <= NONE;
      alloc_err_o <= 1'b0;
    end else begin
      alloc_gnt_o <= pop_ok;
      alloc_idx_o <= pop_idx;
      alloc_err_o <= alloc_req_i && !pop_ok;
    end
  end

  assign free_avail_o = (free_head_o != NONE);
  assign ref_err_o    = |err_v;

  // R3
  err_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_err_o |-> !alloc_gnt_o);

  // R2
  grant_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt_o |-> (busy_o[alloc_idx_o[PTR_W-1:0]] && inwin_o[alloc_idx_o[PTR_W-1:0]]));

  // R10
  special_off_list_chk: assert property (@(posedge clk) disable iff (rst)
    free_avail_o |-> (free_head_o >= IDX_W'(NUM_SPECIAL)));

  // R11
  one_free_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(free_sel));
endmodule

// File: tb/prt_reclaim_tracker_tb.sv
module prt_reclaim_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int S  = 2;
  localparam int IW = 4;
  localparam int NONE = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_req_i = 1'b0;
  logic alloc_gnt_o, alloc_err_o, free_avail_o, ref_err_o;
  logic [IW-1:0] alloc_idx_o, free_head_o;
  logic occupy_vld_i = 0, wb_vld_i = 0, macq_vld_i = 0, mrel_vld_i = 0, radd_vld_i = 0, rdone_vld_i = 0;
  logic [IW-1:0] occupy_idx_i = 0, wb_idx_i = 0, macq_idx_i = 0, mrel_idx_i = 0, radd_idx_i = 0, rdone_idx_i = 0;
  logic [N-1:0] busy_o, mapped_o, inwin_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prt_reclaim_tracker #(.NUM_REGS(N), .NUM_SPECIAL(S), .REF_W(4), .MAP_W(3)) u_dut (
    .clk(clk), .rst(rst),
    .alloc_req_i(alloc_req_i), .alloc_gnt_o(alloc_gnt_o), .alloc_idx_o(alloc_idx_o), .alloc_err_o(alloc_err_o),
    .occupy_vld_i(occupy_vld_i), .occupy_idx_i(occupy_idx_i),
    .wb_vld_i(wb_vld_i), .wb_idx_i(wb_idx_i),
    .macq_vld_i(macq_vld_i), .macq_idx_i(macq_idx_i),
    .mrel_vld_i(mrel_vld_i), .mrel_idx_i(mrel_idx_i),
    .radd_vld_i(radd_vld_i), .radd_idx_i(radd_idx_i),
    .rdone_vld_i(rdone_vld_i), .rdone_idx_i(rdone_idx_i),
    .free_head_o(free_head_o), .free_avail_o(free_avail_o),
    .busy_o(busy_o), .mapped_o(mapped_o), .inwin_o(inwin_o), .ref_err_o(ref_err_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr();
    alloc_req_i = 0; occupy_vld_i = 0; wb_vld_i = 0; macq_vld_i = 0;
    mrel_vld_i = 0; radd_vld_i = 0; rdone_vld_i = 0;
  endtask

  // kind: 0 map release, 1 writeback, 2 reader done, 3 reader add, 4 map acquire, 5 occupy
  task automatic pulse(int kind, int r);
    case (kind)
      0: begin mrel_vld_i = 1;   mrel_idx_i = IW'(r);   end
      1: begin wb_vld_i = 1;     wb_idx_i = IW'(r);     end
      2: begin rdone_vld_i = 1;  rdone_idx_i = IW'(r);  end
      3: begin radd_vld_i = 1;   radd_idx_i = IW'(r);   end
      4: begin macq_vld_i = 1;   macq_idx_i = IW'(r);   end
      default: begin occupy_vld_i = 1; occupy_idx_i = IW'(r); end
    endcase
    tick();
    clr();
  endtask

  task automatic alloc();
    alloc_req_i = 1;
    tick();
    alloc_req_i = 0;
  endtask

  int ord [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};

  initial begin
    clr();
    repeat (3) tick();
    rst = 0;
    chk("R1 head", free_head_o, S);
    chk("R1 avail", free_avail_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 mapped", mapped_o, (1 << S) - 1);
    chk("R1 inwin", inwin_o, 0);
    chk("R1 gnt", alloc_gnt_o, 0);

    for (int k = 0; k < N - S; k++) begin
      alloc();
      chk("R2 gnt", alloc_gnt_o, 1);
      chk("R2 idx", alloc_idx_o, S + k);
      chk("R2 busy", busy_o[S + k], 1);
      chk("R2 inwin", inwin_o[S + k], 1);
      chk("R2 head", free_head_o, (k < N - S - 1) ? S + k + 1 : NONE);
    end
    alloc();
    chk("R3 err", alloc_err_o, 1);
    chk("R3 gnt", alloc_gnt_o, 0);
    chk("R3 head", free_head_o, NONE);
    tick();
    chk("R3 err pulse", alloc_err_o, 0);

    for (int r = S; r < N; r++) begin
      for (int p = 0; p < 6; p++) begin
        macq_vld_i = 1; macq_idx_i = IW'(r); radd_vld_i = 1; radd_idx_i = IW'(r);
        tick(); clr();
        pulse(4, r);
        chk("R4 mapped set", mapped_o[r], 1);
        for (int s = 0; s < 3; s++) begin
          case (ord[p][s])
            0: begin
              pulse(0, r);
              chk("R4 mapped held at count one", mapped_o[r], 1);
              pulse(0, r);
            end
            1: begin
              pulse(1, r);
              chk("R5 inwin clear", inwin_o[r], 0);
            end
            default: pulse(2, r);
          endcase
          tick();
          if (s < 2) begin
            chk("R7 not freed early", busy_o[r], 1);
            chk("R7 head empty", free_head_o, NONE);
          end else begin
            chk("R7 freed busy", busy_o[r], 0);
            chk("R7 freed mapped", mapped_o[r], 0);
            chk("R8 head is freed", free_head_o, r);
            chk("R8 avail", free_avail_o, 1);
          end
        end
        alloc();
        chk("R8 realloc idx", alloc_idx_o, r);
        chk("R8 head after realloc", free_head_o, NONE);
        chk("R6 no error", ref_err_o, 0);
      end
    end

    pulse(2, 2);
    chk("R6 underflow err", ref_err_o, 1);
    tick();
    chk("R6 err pulse", ref_err_o, 0);
    pulse(1, 2);
    tick();
    chk("R6 count held at zero", free_head_o, 2);

    for (int i = 0; i < 3; i++) pulse(3, 3);
    pulse(1, 3);
    for (int i = 0; i < 2; i++) begin
      pulse(2, 3);
      tick();
      chk("R6 readers pending", busy_o[3], 1);
    end
    pulse(2, 3);
    tick();
    chk("R8 lifo head", free_head_o, 3);
    alloc();
    chk("R8 lifo first", alloc_idx_o, 3);
    alloc();
    chk("R8 lifo second", alloc_idx_o, 2);
    chk("R8 empty", free_avail_o, 0);

    pulse(3, 4);
    pulse(1, 4);
    rdone_vld_i = 1; rdone_idx_i = 4;
    tick(); clr();
    alloc();
    chk("R9 gnt", alloc_gnt_o, 1);
    chk("R9 idx", alloc_idx_o, 4);
    chk("R9 err", alloc_err_o, 0);
    chk("R9 busy", busy_o[4], 1);
    chk("R9 inwin", inwin_o[4], 1);
    chk("R9 head", free_head_o, NONE);

    pulse(1, 5);
    tick();
    chk("R7 plain free", free_head_o, 5);
    pulse(3, 6);
    pulse(1, 6);
    pulse(2, 6);
    alloc();
    chk("R9 idx nonempty", alloc_idx_o, 6);
    chk("R9 head kept", free_head_o, 5);
    alloc();
    chk("R9 next", alloc_idx_o, 5);

    pulse(3, 2);
    pulse(1, 2);
    wb_vld_i = 1; wb_idx_i = 3; rdone_vld_i = 1; rdone_idx_i = 2;
    tick(); clr();
    tick();
    chk("R11 lowest first", free_head_o, 2);
    chk("R11 other waits", busy_o[3], 1);
    tick();
    chk("R11 second", free_head_o, 3);
    chk("R11 both freed", busy_o[3:2], 0);

    pulse(5, 0);
    chk("R10 occupy busy", busy_o[0], 1);
    chk("R10 occupy inwin", inwin_o[0], 1);
    pulse(3, 0);
    pulse(1, 0);
    tick();
    chk("R10 reader holds", busy_o[0], 1);
    pulse(2, 0);
    tick();
    chk("R10 idle busy", busy_o[0], 0);
    chk("R10 idle mapped", mapped_o[0], 1);
    chk("R10 not listed", free_head_o, 3);
    pulse(0, 0);
    tick();
    chk("R10 map release ignored", mapped_o[0], 1);
    chk("R10 head unchanged", free_head_o, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule